// File: doc/BRIEF.md
# Physical memory protection checker

This block guards physical memory for a 32-bit core. It holds sixteen protection entries. Each entry has a configuration byte, an address register, a 4-bit cacheability attribute and a 2-bit security/IOMMU control field. All of these are loaded through a single-cycle CSR write port. The lookup side is purely combinational. For each access it takes a 34-bit physical address, an access kind and a privilege flag. It returns whether the access is allowed, whether any entry matched, and the attribute and security fields of the entry that decided the outcome.

An entry matches in one of three ways. Top-of-range mode uses the previous entry's address register as the lower bound. Exact-word mode matches one aligned 4-byte word. Power-of-two mode covers a naturally aligned block. Locking an entry freezes its configuration and address until reset. A locked entry also applies its permissions to machine mode. Locking a top-of-range entry freezes the address register of the entry below it as well.

Top module: `pmp_checker`

## Requirements
- R1: After reset every entry is off and unlocked, and its address, attribute and security fields are zero. In this state no lookup matches, machine accesses are allowed and lower-privilege accesses are denied.
- R2: CSR 0x3A0+n holds the configuration bytes of entries 4n..4n+3, with entry 4n+j at bits 8j+7:8j. Within a byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the mode (0 off, 1 top-of-range, 2 exact word, 3 power-of-two) and bit 7 is lock. Bits 6:5 are stored as zero. CSR 0x3B0+i holds physical address bits 33:2 of entry i.
- R3: While an entry is locked, writes to its configuration byte and its address register are ignored until reset.
- R4: While entry i+1 is locked and in top-of-range mode, writes to the address register of entry i are ignored.
- R5: A top-of-range entry i matches word addresses w with lower <= w < own register. The lower bound is the register of entry i-1, or zero for entry 0.
- R6: An exact-word entry matches only the word equal to its register. A power-of-two entry whose register ends in k trailing ones matches the aligned block of 2^(k+3) bytes that contains it. All ones covers the whole space.
- R7: The lowest-numbered matching entry decides. With no match, a machine access is allowed and a lower-privilege access is denied.
- R8: The access kind is 0 read, 1 write, 2 execute and 3 reserved; the reserved kind is never permitted by a bit. A matching entry grants a lower-privilege access only if the kind's bit is set. It applies to machine accesses only when locked; otherwise a machine access that it matches is allowed.
- R9: CSR 0x7D8 holds the attributes of entries 0..7 and CSR 0x7D9 those of entries 8..15. Entry i uses bits 4(i%8)+3:4(i%8). Only the codes 0, 2, 3, 7, 11 and 15 are accepted. A nibble with any other code leaves that entry's attribute unchanged, while legal nibbles in the same write still take effect.
- R10: CSR 0x7DA holds the security field of entry i at bits 2i+1:2i (0 secure, 1 non-secure, 2 secure with IOMMU, 3 non-secure with IOMMU).
- R11: The attribute and security outputs are those of the deciding entry. They are zero when nothing matches, so the fields of an entry that is off never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR number |
| csr_wdata | input | 32 | CSR write data |
| chk_addr | input | 34 | Physical address under test |
| chk_type | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| chk_machine | input | 1 | 1 for machine privilege |
| chk_allow | output | 1 | Access permitted |
| chk_hit | output | 1 | Some entry matched |
| chk_attr | output | 4 | Attribute of the deciding entry |
| chk_sec | output | 2 | Security field of the deciding entry |

## Verification
The lookup is combinational over the stored state. A corrupted configuration byte, address bound or field therefore shows at the outputs as soon as an address inside the affected region is presented, on the cycle after the bad write. A lock rule that leaks lets a later write move a bound or clear a permission, and the next lookup near that bound exposes it. The reference model is compared on every cycle against directed region setups and a long random mix of CSR writes and lookups near the stored bounds.

// File: rtl/pmp_checker.sv
module pmp_checker #(
  parameter int NUM_ENTRIES = 16,
  parameter int PA_W        = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [11:0]      csr_addr,
  input  logic [31:0]      csr_wdata,
  input  logic [PA_W-1:0]  chk_addr,
  input  logic [1:0]       chk_type,
  input  logic             chk_machine,
  output logic             chk_allow,
  output logic             chk_hit,
  output logic [3:0]       chk_attr,
  output logic [1:0]       chk_sec
);

  localparam int AW    = PA_W - 2;
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam logic [11:0] CFG_CSR  = 12'h3A0;
  localparam logic [11:0] ADDR_CSR = 12'h3B0;
  localparam logic [11:0] ATTR_CSR = 12'h7D8;
  localparam logic [11:0] SEC_CSR  = 12'h7DA;
  localparam logic [7:0]  CFG_KEEP = 8'h9F;
  localparam logic [1:0]  M_OFF = 2'd0, M_TOR = 2'd1, M_NA4 = 2'd2, M_NAPOT = 2'd3;

  function automatic logic attr_legal(input logic [3:0] c);
    return c inside {4'd0, 4'd2, 4'd3, 4'd7, 4'd11, 4'd15};
  endfunction

  logic [7:0]    cfg_q    [NUM_ENTRIES];
  logic [AW-1:0] addr_q   [NUM_ENTRIES];
  logic [3:0]    attr_q   [NUM_ENTRIES];
  logic [1:0]    sec_q    [NUM_ENTRIES];
  logic [AW-1:0] lo_bound [NUM_ENTRIES];
  logic [AW-1:0] nap_mask [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] tor_guard, hit_vec;

  always_comb begin
    tor_guard = '0;
    for (int i = 0; i < NUM_ENTRIES - 1; i++)
      tor_guard[i] = cfg_q[i+1][7] && (cfg_q[i+1][4:3] == M_TOR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        cfg_q[i]  <= '0;
        addr_q[i] <= '0;
        attr_q[i] <= '0;
        sec_q[i]  <= '0;
      end
    end else if (csr_we) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (csr_addr == CFG_CSR + 12'(i / 4) && !cfg_q[i][7])
          cfg_q[i] <= csr_wdata[8*(i%4) +: 8] & CFG_KEEP;
        if (csr_addr == ADDR_CSR + 12'(i) && !cfg_q[i][7] && !tor_guard[i])
          addr_q[i] <= csr_wdata[AW-1:0];
        if (csr_addr == ATTR_CSR + 12'(i / 8) && attr_legal(csr_wdata[4*(i%8) +: 4]))
          attr_q[i] <= csr_wdata[4*(i%8) +: 4];
        if (csr_addr == SEC_CSR + 12'(i / 16))
          sec_q[i] <= csr_wdata[2*(i%16) +: 2];
      end
    end
  end

  wire [AW-1:0] word = chk_addr[PA_W-1:2];

  always_comb begin
    lo_bound[0] = '0;
    for (int i = 1; i < NUM_ENTRIES; i++) lo_bound[i] = addr_q[i-1];
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      nap_mask[i] = ~(addr_q[i] ^ (addr_q[i] + 1'b1));
      case (cfg_q[i][4:3])
        M_TOR:   hit_vec[i] = (word >= lo_bound[i]) && (word < addr_q[i]);
        M_NA4:   hit_vec[i] = (word == addr_q[i]);
        M_NAPOT: hit_vec[i] = ((word ^ addr_q[i]) & nap_mask[i]) == '0;
        default: hit_vec[i] = 1'b0;
      endcase
    end
  end

  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  logic             perm;

  always_comb begin
    win_hit = 1'b0;
    win_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) begin
        win_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
  end

  wire [7:0] win_cfg = cfg_q[win_idx];

  always_comb begin
    case (chk_type)
      2'd0:    perm = win_cfg[0];
      2'd1:    perm = win_cfg[1];
      2'd2:    perm = win_cfg[2];
      default: perm = 1'b0;
    endcase
  end

  assign chk_hit   = win_hit;
  assign chk_allow = win_hit ? ((chk_machine && !win_cfg[7]) || perm) : chk_machine;
  assign chk_attr  = win_hit ? attr_q[win_idx] : 4'd0;
  assign chk_sec   = win_hit ? sec_q[win_idx] : 2'd0;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_chk
    p_lock_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[g][7] |=> $stable(cfg_q[g]));
    p_lock_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[g][7] |=> $stable(addr_q[g]));
    p_attr_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      attr_legal(attr_q[g]));
    if (g < NUM_ENTRIES - 1) begin : g_tor
      p_tor_lower_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[g+1][7] && cfg_q[g+1][4:3] == M_TOR) |=> $stable(addr_q[g]));
    end
  end

  p_nomatch_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_hit |-> (chk_allow == chk_machine));
  p_reserved_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_type == 2'd3 && !chk_machine) |-> !chk_allow);
  p_nomatch_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_hit |-> (chk_attr == 4'd0 && chk_sec == 2'd0));

endmodule

// File: tb/pmp_checker_tb.sv
`timescale 1ns/1ps
module pmp_checker_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [33:0] chk_addr = '0;
  logic [1:0]  chk_type = '0;
  logic        chk_machine = 0;
  logic        chk_allow, chk_hit;
  logic [3:0]  chk_attr;
  logic [1:0]  chk_sec;

  int n_tests = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;

  always #2.5 clk = ~clk;

  pmp_checker u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .chk_addr(chk_addr), .chk_type(chk_type), .chk_machine(chk_machine),
    .chk_allow(chk_allow), .chk_hit(chk_hit), .chk_attr(chk_attr), .chk_sec(chk_sec));

  logic [7:0]  m_cfg  [16];
  logic [31:0] m_addr [16];
  logic [3:0]  m_attr [16];
  logic [1:0]  m_sec  [16];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_cfg[i] = 0; m_addr[i] = 0; m_attr[i] = 0; m_sec[i] = 0;
      end
    end else if (csr_we) begin
      for (int i = 0; i < 16; i++) begin
        logic [3:0] nib;
        if (csr_addr == 12'h3A0 + 12'(i / 4) && !m_cfg[i][7])
          m_cfg[i] = 8'((csr_wdata >> (8 * (i % 4))) & 32'h9F);
        if (csr_addr == 12'h3B0 + 12'(i) && !m_cfg[i][7] &&
            !(i < 15 && m_cfg[i+1][7] && m_cfg[i+1][4:3] == 2'd1))
          m_addr[i] = csr_wdata;
        nib = 4'((csr_wdata >> (4 * (i % 8))) & 32'hF);
        if (csr_addr == 12'h7D8 + 12'(i / 8) && (nib inside {0, 2, 3, 7, 11, 15}))
          m_attr[i] = nib;
        if (csr_addr == 12'h7DA)
          m_sec[i] = 2'((csr_wdata >> (2 * i)) & 32'h3);
      end
    end
  end

  function automatic void ref_look(input logic [33:0] pa, input logic [1:0] ty, input bit mach,
                                   output bit allow, output bit hit, output int attr, output int sec);
    longint a = longint'(pa >> 2);
    hit = 0; allow = mach; attr = 0; sec = 0;
    for (int i = 0; i < 16; i++) begin
      longint hi = longint'({32'd0, m_addr[i]});
      longint lo = (i == 0) ? 0 : longint'({32'd0, m_addr[i-1]});
      bit m = 0;
      if (!hit) begin
        case (m_cfg[i][4:3])
          2'd1: m = (a >= lo) && (a < hi);
          2'd2: m = (a == hi);
          2'd3: begin
            int k = 0;
            longint size, base;
            while (k < 32 && m_addr[i][k]) k++;
            size = longint'(1) << (k + 1);
            base = hi - (hi % size);
            m = (a >= base) && (a < base + size);
          end
          default: m = 0;
        endcase
        if (m) begin
          bit p;
          hit = 1; attr = m_attr[i]; sec = m_sec[i];
          p = (ty == 0) ? m_cfg[i][0] : (ty == 1) ? m_cfg[i][1] : (ty == 2) ? m_cfg[i][2] : 1'b0;
          allow = (mach && !m_cfg[i][7]) || p;
        end
      end
    end
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      bit ea, eh; int eat, es;
      #2;
      ref_look(chk_addr, chk_type, chk_machine, ea, eh, eat, es);
      n_tests++;
      if (chk_allow !== ea || chk_hit !== eh || chk_attr !== 4'(eat) || chk_sec !== 2'(es)) begin
        n_fail++;
        $display("FAIL cycle compare R5 R6 R7 R8 R11 addr=%h: got allow/hit/attr/sec %0d/%0d/%0d/%0d, expected %0d/%0d/%0d/%0d",
                 chk_addr, chk_allow, chk_hit, chk_attr, chk_sec, ea, eh, eat, es);
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d, expected %0d", req, got, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic look(input logic [33:0] pa, input logic [1:0] ty, input bit m);
    @(negedge clk);
    chk_addr = pa; chk_type = ty; chk_machine = m;
    #1;
  endtask

  task automatic do_reset();
    cmp_en = 0;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    cmp_en = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    look(34'h100, 0, 0); check("R1 user denied after reset", chk_allow, 0);
    check("R1 no hit after reset", chk_hit, 0);
    look(34'h100, 1, 1); check("R1 machine allowed after reset", chk_allow, 1);

    csr_wr(12'h3B0, 32'h400);
    csr_wr(12'h3A0, 32'h09);
    look(34'hFFC, 0, 0);  check("R5 TOR top word", chk_allow, 1);
    look(34'h0, 0, 0);    check("R5 TOR entry0 lower bound zero", chk_allow, 1);
    look(34'h1000, 0, 0); check("R5 TOR upper bound exclusive", chk_hit, 0);
    look(34'hFFC, 1, 0);  check("R8 write without W bit", chk_allow, 0);

    csr_wr(12'h3B1, 32'h803);
    csr_wr(12'h3A0, 32'h1B09);
    look(34'h201C, 1, 0); check("R6 NAPOT 32-byte last word", chk_allow, 1);
    look(34'h2000, 0, 0); check("R6 NAPOT first word", chk_hit, 1);
    look(34'h2020, 0, 0); check("R6 NAPOT past end", chk_hit, 0);

    csr_wr(12'h3B2, 32'hC00);
    csr_wr(12'h3A0, 32'h141B09);
    look(34'h3000, 2, 0); check("R6 NA4 exec on word", chk_allow, 1);
    look(34'h3004, 2, 0); check("R6 NA4 next word", chk_hit, 0);

    csr_wr(12'h3B3, 32'hFFFF_FFFF);
    csr_wr(12'h3A0, 32'h1814_1B09);
    look(34'h5000, 0, 0); check("R7 catch-all denies", chk_allow, 0);
    look(34'h5000, 0, 0); check("R6 all-ones NAPOT covers space", chk_hit, 1);
    look(34'h10, 0, 0);   check("R7 lower entry wins", chk_allow, 1);

    csr_wr(12'h7D8, 32'h375F);
    look(34'h10, 0, 0);   check("R9 legal attr entry0", chk_attr, 15);
    look(34'h2000, 0, 0); check("R9 illegal attr kept", chk_attr, 0);
    look(34'h3000, 2, 0); check("R9 legal attr entry2", chk_attr, 7);
    look(34'h5000, 0, 0); check("R11 winner attr entry3", chk_attr, 3);

    csr_wr(12'h7DA, 32'h6);
    look(34'h10, 0, 0);   check("R10 sec entry0", chk_sec, 2);
    look(34'h2000, 0, 0); check("R10 sec entry1", chk_sec, 1);

    look(34'h10, 1, 1);   check("R8 machine ignores unlocked entry", chk_allow, 1);
    look(34'h2000, 3, 0); check("R8 reserved kind denied", chk_allow, 0);

    csr_wr(12'h3A0, 32'h0014_1B09);
    csr_wr(12'h3B3, 32'h1400);
    csr_wr(12'h3B4, 32'h1800);
    csr_wr(12'h3A1, 32'h89);
    look(34'h5800, 1, 1); check("R8 locked entry binds machine", chk_allow, 0);
    look(34'h5800, 0, 1); check("R8 locked read allowed", chk_allow, 1);
    look(34'h4800, 1, 1); check("R7 machine default allow", chk_allow, 1);
    csr_wr(12'h3B3, 32'h1000);
    look(34'h4800, 0, 0); check("R4 lower bound write ignored", chk_allow, 0);
    look(34'h5000, 0, 0); check("R4 lower bound unchanged", chk_allow, 1);
    csr_wr(12'h3B4, 32'h2000);
    look(34'h6000, 0, 0); check("R3 locked addr write ignored", chk_allow, 0);
    look(34'h6000, 0, 0); check("R11 no-hit fields zero", chk_attr + chk_sec, 0);
    csr_wr(12'h3A1, 32'h0);
    look(34'h5000, 0, 0); check("R3 locked cfg write ignored", chk_allow, 1);
    csr_wr(12'h3A1, 32'h0);
    look(34'h5800, 1, 1); check("R2 lock bit still set", chk_allow, 0);

    do_reset();
    look(34'h5000, 0, 0); check("R1 reset clears lock", chk_hit, 0);
    look(34'h5800, 1, 1); check("R1 machine allowed after reset", chk_allow, 1);

    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 10;
      if (r < 3) begin
        logic [11:0] a;
        logic [31:0] d = $urandom;
        int s = $urandom % 4;
        if (s == 0) begin
          a = 12'h3A0 + 12'($urandom % 4);
          if ($urandom % 8 != 0) d = d & 32'h7F7F_7F7F;
        end else if (s == 1) begin
          a = 12'h3B0 + 12'($urandom % 16);
          d = d & 32'h0000_3FFF;
          if ($urandom % 4 == 0) d = d | 32'h7;
        end else if (s == 2) a = 12'h7D8 + 12'($urandom % 2);
        else a = 12'h7DA;
        csr_wr(a, d);
      end else begin
        logic [33:0] pa;
        if ($urandom % 2 == 0) pa = {m_addr[$urandom % 16], 2'b00} + 34'($urandom % 24) - 34'd8;
        else pa = {2'b00, 32'($urandom)} & 34'h0_0000_FFFC;
        look(pa, 2'($urandom % 4), 1'($urandom % 2));
      end
    end

    @(negedge clk);
    cmp_en = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule